// File: doc/BRIEF.md
# Grouped Chip-Select Address Decoder

This block turns a 32-bit bus address into sixteen active-low chip-select lines. The selects are organised as four groups of four. Decoding runs in two stages. First, a group checks the top twelve address bits against its base field, with a per-group mask that can make some of those bits don't-care. Second, each select checks the next eight address bits against the compare field and mask in its own option register. A per-group valid flag gates all four selects of that group.

Software programs the base, mask and option registers through a simple synchronous write port. Until group 0 is marked valid, its first select acts as the boot device select. It asserts on every strobed access, so a processor can fetch its start-up code from that device before any decoding is set up.

The outputs are registered. A select therefore reflects the address and strobe that were sampled on the previous clock edge. All matching selects assert together. Keeping regions from overlapping is left to software.

Top module: `csdec_top`

## Requirements
- R1: A synchronous active-high reset clears every base, mask and option register to 0x0000 and drives all sixteen cs_n outputs high.
- R2: While the valid flag of group 0 (bit 0 of register index 0) is 0, cs_n[0] goes low for every access with as_n low, whatever the address. cs_n[1] to cs_n[3] stay high during that time.
- R3: A select other than cs_n[0] never goes low while the valid flag (bit 0) of its group's base register is 0.
- R4: A group matches when address bits 31..20 equal base register bits 15..4 in every position where mask register bits 15..4 hold 0. A mask bit of 1 makes the corresponding address bit don't-care.
- R5: A select matches when address bits 19..12 equal option register bits 15..8 in every position where option register bits 7..0 hold 0. A bit of 1 in bits 7..0 makes the corresponding address bit don't-care.
- R6: Once its group is valid, a select goes low only when both the group match and its own select match hold. This rule also applies to cs_n[0] once group 0 is valid.
- R7: While as_n is high, every cs_n output is high.
- R8: When several selects match one address, all of them go low in the same cycle.
- R9: A write with wr_en high stores wr_data at wr_idx. Indices 0..3 are the base registers of groups 0..3, indices 4..7 are the mask registers of groups 0..3, and index 8+4g+s is the option register of select s in group g. Select s of group g drives cs_n[4g+s]. A written value governs an access presented in the next cycle.
- R10: cs_n is registered. It shows the decode of bus_addr and as_n as sampled on the previous rising clock edge, and it does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register index for a write |
| wr_data | input | 16 | Register write data |
| bus_addr | input | 32 | Bus address |
| as_n | input | 1 | Address strobe, active low |
| cs_n | output | 16 | Chip selects, active low, bit 4g+s for select s of group g |

## Verification
The decoder is tried with addresses that land in a group with a zero mask, and with addresses that land in a group whose mask widens it to four windows. This separates exact upper-bit compare from masked compare. Within each group, addresses are chosen to hit one select only, two overlapping selects at once, a select that uses its low-field mask, and no select at all. This separates the select compare, the mask handling and multi-hit behaviour. Further patterns aim at an invalid group, at addresses with the strobe off, and at arbitrary addresses before and after group 0 becomes valid. These show whether the valid gating and the boot exemption act independently of the address match. A reset in mid-run confirms that the boot behaviour returns.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  // Compare under mask: a mask bit of 1 removes that bit from the compare.
  function automatic logic masked_eq12(input logic [11:0] a,
                                       input logic [11:0] b,
                                       input logic [11:0] dc);
    return ((a ^ b) & ~dc) == '0;
  endfunction

  function automatic logic masked_eq8(input logic [7:0] a,
                                      input logic [7:0] b,
                                      input logic [7:0] dc);
    return ((a ^ b) & ~dc) == '0;
  endfunction

  localparam int unsigned VALID_BIT = 0;

endpackage

// File: rtl/csdec_regfile.sv
module csdec_regfile #(
  parameter int NUM_GRP     = 4,
  parameter int SEL_PER_GRP = 4,
  parameter int REG_W       = 16,
  parameter int REG_AW      = 5
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    wr_en,
  input  logic [REG_AW-1:0]                       wr_idx,
  input  logic [REG_W-1:0]                        wr_data,
  output logic [NUM_GRP-1:0][REG_W-1:0]           base_o,
  output logic [NUM_GRP-1:0][REG_W-1:0]           mask_o,
  output logic [NUM_GRP*SEL_PER_GRP-1:0][REG_W-1:0] opt_o
);
  localparam int NUM_SEL  = NUM_GRP * SEL_PER_GRP;
  localparam int MASK_OFS = NUM_GRP;
  localparam int OPT_OFS  = 2 * NUM_GRP;
  localparam int REG_CNT  = OPT_OFS + NUM_SEL;

  // Every register feeds the decoder at once, so flops rather than RAM.
  logic [REG_W-1:0] regs_q [REG_CNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_CNT; i++) regs_q[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < REG_CNT)) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_out
    assign base_o[g] = regs_q[g];
    assign mask_o[g] = regs_q[MASK_OFS + g];
  end

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_opt_out
    assign opt_o[s] = regs_q[OPT_OFS + s];
  end

endmodule

// File: rtl/csdec_grp_match.sv
module csdec_grp_match #(
  parameter int REG_W = 16,
  parameter int HI_W  = 12
) (
  input  logic [HI_W-1:0]  addr_hi,
  input  logic [REG_W-1:0] base_reg,
  input  logic [REG_W-1:0] mask_reg,
  output logic             hit_o,
  output logic             valid_o
);
  import csdec_pkg::*;

  localparam int FLD_LSB = REG_W - HI_W;

  logic [HI_W-1:0] base_fld;
  logic [HI_W-1:0] mask_fld;
  logic            unused_fields;

  assign base_fld = base_reg[REG_W-1:FLD_LSB];
  assign mask_fld = mask_reg[REG_W-1:FLD_LSB];
  assign unused_fields = ^{base_reg[FLD_LSB-1:1], mask_reg[FLD_LSB-1:0]};

  assign hit_o   = masked_eq12(addr_hi, base_fld, mask_fld);
  assign valid_o = base_reg[VALID_BIT];

endmodule

// File: rtl/csdec_sel_match.sv
module csdec_sel_match #(
  parameter int REG_W = 16,
  parameter int LO_W  = 8
) (
  input  logic [LO_W-1:0]  addr_lo,
  input  logic [REG_W-1:0] opt_reg,
  output logic             hit_o
);
  import csdec_pkg::*;

  logic [LO_W-1:0] cmp_fld;
  logic [LO_W-1:0] dc_fld;

  assign cmp_fld = opt_reg[REG_W-1 -: LO_W];
  assign dc_fld  = opt_reg[LO_W-1:0];
  assign hit_o   = masked_eq8(addr_lo, cmp_fld, dc_fld);

endmodule

// File: rtl/csdec_top.sv
module csdec_top #(
  parameter int NUM_GRP     = 4,
  parameter int SEL_PER_GRP = 4,
  parameter int ADDR_W      = 32,
  parameter int REG_W       = 16,
  parameter int HI_W        = 12,
  parameter int LO_W        = 8,
  parameter int REG_AW      = $clog2(2 * NUM_GRP + NUM_GRP * SEL_PER_GRP)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [REG_AW-1:0]                wr_idx,
  input  logic [REG_W-1:0]                 wr_data,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             as_n,
  output logic [NUM_GRP*SEL_PER_GRP-1:0]   cs_n
);
  localparam int NUM_SEL = NUM_GRP * SEL_PER_GRP;
  localparam int HI_LSB  = ADDR_W - HI_W;
  localparam int LO_LSB  = HI_LSB - LO_W;
  localparam int BOOT    = 0;

  logic [NUM_GRP-1:0][REG_W-1:0] base_w;
  logic [NUM_GRP-1:0][REG_W-1:0] mask_w;
  logic [NUM_SEL-1:0][REG_W-1:0] opt_w;
  logic [NUM_GRP-1:0]            grp_hit;
  logic [NUM_GRP-1:0]            grp_vld;
  logic [NUM_SEL-1:0]            sel_hit;
  logic [NUM_SEL-1:0]            cs_hit;
  logic [NUM_SEL-1:0]            cs_n_q;
  logic [HI_W-1:0]               addr_hi;
  logic [LO_W-1:0]               addr_lo;
  logic                          unused_addr;

  assign addr_hi     = bus_addr[ADDR_W-1:HI_LSB];
  assign addr_lo     = bus_addr[HI_LSB-1:LO_LSB];
  assign unused_addr = ^bus_addr[LO_LSB-1:0];

  csdec_regfile #(
    .NUM_GRP    (NUM_GRP),
    .SEL_PER_GRP(SEL_PER_GRP),
    .REG_W      (REG_W),
    .REG_AW     (REG_AW)
  ) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .base_o (base_w),
    .mask_o (mask_w),
    .opt_o  (opt_w)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    csdec_grp_match #(
      .REG_W(REG_W),
      .HI_W (HI_W)
    ) grp_i (
      .addr_hi (addr_hi),
      .base_reg(base_w[g]),
      .mask_reg(mask_w[g]),
      .hit_o   (grp_hit[g]),
      .valid_o (grp_vld[g])
    );

    for (genvar s = 0; s < SEL_PER_GRP; s++) begin : g_sel
      localparam int IDX = g * SEL_PER_GRP + s;

      csdec_sel_match #(
        .REG_W(REG_W),
        .LO_W (LO_W)
      ) sel_i (
        .addr_lo(addr_lo),
        .opt_reg(opt_w[IDX]),
        .hit_o  (sel_hit[IDX])
      );

      if (IDX == BOOT) begin : g_boot
        // Boot select: any access until its group is made valid.
        assign cs_hit[IDX] = grp_vld[g] ? (grp_hit[g] & sel_hit[IDX]) : 1'b1;
      end else begin : g_norm
        assign cs_hit[IDX] = grp_vld[g] & grp_hit[g] & sel_hit[IDX];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cs_n_q <= '1;
    else     cs_n_q <= ~(cs_hit & {NUM_SEL{~as_n}});
  end

  assign cs_n = cs_n_q;

endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
  parameter int NUM_GRP     = 4,
  parameter int SEL_PER_GRP = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           as_n,
  input logic [NUM_GRP*SEL_PER_GRP-1:0] cs_n,
  input logic [NUM_GRP-1:0]             grp_vld
);
  localparam int NUM_SEL = NUM_GRP * SEL_PER_GRP;

  // R1: reset leaves every select idle on the following edge
  p_rst_idle_r1: assert property (@(posedge clk) rst |=> (&cs_n));

  // R7: no strobe, no select
  p_strobe_gate_r7: assert property (@(posedge clk) disable iff (rst)
    as_n |=> (&cs_n));

  // R2: boot select fires on any strobed access while group 0 is invalid
  p_boot_any_r2: assert property (@(posedge clk) disable iff (rst)
    (!as_n && !grp_vld[0]) |=> !cs_n[0]);

  // R3: invalid group keeps its non-boot selects idle
  for (genvar i = 1; i < NUM_SEL; i++) begin : g_inv
    p_invalid_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !grp_vld[i / SEL_PER_GRP] |=> cs_n[i]);
  end

  // R10: outputs only move at the clock edge
  always @(cs_n) begin
    if (!rst) p_edge_only_r10: assert (clk === 1'b1);
  end

endmodule

bind csdec_top csdec_chk #(
  .NUM_GRP    (NUM_GRP),
  .SEL_PER_GRP(SEL_PER_GRP)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .as_n   (as_n),
  .cs_n   (cs_n),
  .grp_vld(grp_vld)
);

// File: tb/csdec_top_tb_top.sv
module csdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [31:0] bus_addr = '0;
  logic        as_n = 1'b1;
  logic [15:0] cs_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  csdec_top dut_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .bus_addr(bus_addr),
    .as_n    (as_n),
    .cs_n    (cs_n)
  );

  // {address, expected active selects (1 = asserted)}
  localparam int NVEC = 16;
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h0000_0000, 16'h0001},
    {32'h000F_F000, 16'h0008},
    {32'h0001_0000, 16'h0006},
    {32'h0001_1000, 16'h0004},
    {32'h0000_5ABC, 16'h0001},
    {32'h4000_0000, 16'h0010},
    {32'h4037_7000, 16'h0010},
    {32'h4040_0000, 16'h0000},
    {32'h8000_0000, 16'h0000},
    {32'hF008_0000, 16'h3000},
    {32'hF00F_F000, 16'h2000},
    {32'hF000_1000, 16'h4000},
    {32'hF000_2000, 16'h8000},
    {32'hF000_3000, 16'h0000},
    {32'h1000_0000, 16'h0000},
    {32'h0002_0000, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cs_n actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Present one strobed access, return cs_n seen after the next edge.
  task automatic access(input logic [31:0] a, output logic [15:0] res);
    @(negedge clk);
    bus_addr = a; as_n = 1'b0;
    @(negedge clk);
    res = cs_n;
    as_n = 1'b1;
  endtask

  function automatic string fmt(input string s, input int n);
    return $sformatf("%s #%0d", s, n);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    check("R1 idle in reset", cs_n, 16'hFFFF);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", cs_n, 16'hFFFF);

    // R2: boot select before any programming
    access(32'h1234_5678, r);
    check("R2 boot any address", r, 16'hFFFE);
    access(32'h0000_0000, r);
    check("R2 boot zero address", r, 16'hFFFE);

    // R7: strobe off
    @(negedge clk);
    bus_addr = 32'h0000_0000; as_n = 1'b1;
    @(negedge clk);
    check("R7 strobe high", cs_n, 16'hFFFF);

    // R10: no change before the edge, change after it
    bus_addr = 32'hABCD_0000; as_n = 1'b0;
    #1;
    check("R10 before edge", cs_n, 16'hFFFF);
    @(negedge clk);
    check("R10 after edge", cs_n, 16'hFFFE);
    as_n = 1'b1;
    @(negedge clk);

    // R9: program everything but group 0 base
    wr(5'd1, 16'h4001);
    wr(5'd2, 16'h8000);
    wr(5'd3, 16'hF001);
    wr(5'd4, 16'h0000);
    wr(5'd5, 16'h0030);
    wr(5'd6, 16'h0000);
    wr(5'd7, 16'h0000);
    wr(5'd8,  16'h000F);
    wr(5'd9,  16'h1000);
    wr(5'd10, 16'h1001);
    wr(5'd11, 16'hFF00);
    wr(5'd12, 16'h00FF);
    wr(5'd13, 16'hFF00);
    wr(5'd14, 16'hFF00);
    wr(5'd15, 16'hFF00);
    wr(5'd16, 16'h00FF);
    wr(5'd17, 16'hFF00);
    wr(5'd18, 16'hFF00);
    wr(5'd19, 16'hFF00);
    wr(5'd20, 16'h8000);
    wr(5'd21, 16'h807F);
    wr(5'd22, 16'h0100);
    wr(5'd23, 16'h0200);

    // R2 R8: boot still active, together with group 1
    access(32'h4000_0000, r);
    check("R2 boot plus group 1", r, 16'hFFEE);
    // R3: group 2 invalid, boot only
    access(32'h8000_0000, r);
    check("R3 group 2 invalid", r, 16'hFFFE);

    wr(5'd0, 16'h0001);

    // R4/R5/R6/R8 main decode table
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][47:16], r);
      check(fmt("R4/R5/R6/R8 vector", i), r, ~VEC[i][15:0]);
    end

    // R6: boot select now follows decode
    access(32'h1234_5678, r);
    check("R6 boot decodes after valid", r, 16'hFFFF);

    // R3: clear group 1 valid
    wr(5'd1, 16'h4000);
    access(32'h4000_0000, r);
    check("R3 group 1 cleared", r, 16'hFFFF);

    // R9: enabling group 2 takes effect on the next access
    wr(5'd2, 16'h8001);
    access(32'h8000_0000, r);
    check("R9 group 2 enabled", r, 16'hFEFF);

    // R1: reset in mid-run restores boot behaviour
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", cs_n, 16'hFFFF);
    rst = 1'b0;
    access(32'h8000_0000, r);
    check("R1 registers cleared", r, 16'hFFFE);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule